// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the stream of column addresses that an SDRAM READ or WRITE burst visits, one address per clock. A controller presents a 9-bit starting column, a 3-bit burst-length code and a burst-type bit, then pulses a start strobe. Starting on the next cycle, the block drives a valid flag together with one column address per cycle.

Fixed bursts of 1, 2, 4 or 8 locations stay inside an aligned block of that size. Inside the block the addresses follow either sequential or interleaved order. A continuous full-page burst is also available, but only in sequential order. It walks the whole 512-column page and stops only when the terminate input is asserted. A request with a reserved setting raises a one-cycle error flag and changes nothing else.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is low, and in the cycle after reset is sampled low, `valid_o` and `cfg_err_o` are 0.
- R2: Burst-length code 000 gives 1 location, 001 gives 2, 010 gives 4 and 011 gives 8. After a legal fixed-length start, `valid_o` is high for exactly that many consecutive cycles and then falls, unless a terminate or restart intervenes.
- R3: During a fixed burst of length BL, column bits [8:log2(BL)] equal those of the starting column in every valid cycle.
- R4: With `btype_i` = 0 (sequential), the low log2(BL) bits of the i-th address (i = 0..BL-1) equal (start_low + i) mod BL.
- R5: With `btype_i` = 1 (interleaved), the low log2(BL) bits of the i-th address equal start_low XOR i.
- R6: The first address of a burst appears on `col_o` with `valid_o` high in the cycle after the start strobe is sampled, and it equals the starting column.
- R7: Code 111 with `btype_i` = 0 starts a full-page burst. Address i is (start + i) mod 512, so 511 is followed by 0. The burst continues with no limit until it is terminated.
- R8: If `term_i` is sampled high during a burst and no legal start is sampled in the same cycle, `valid_o` is 0 in the following cycle.
- R9: A start strobe is illegal if its code is 100, 101 or 110, or if it is 111 with `btype_i` = 1. An illegal start makes `cfg_err_o` high for exactly the next cycle, starts no burst, and leaves a running burst unchanged.
- R10: A legal start sampled during a running burst replaces that burst. On the following cycle the new burst's first address is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 9 | Starting column of the burst |
| blen_code_i | input | 3 | Burst-length code |
| btype_i | input | 1 | Order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | `col_o` carries a burst address |
| cfg_err_o | output | 1 | One-cycle flag for a rejected start |

## Verification
The hardest situations to reach are those where two requests overlap. An illegal start can arrive while a burst is running, and it must leave that burst undisturbed. A legal restart can arrive partway through a burst, and it must replace it at once. The bench launches an 8-beat burst and, in the middle of it, drives the second strobe on a chosen beat. It then checks that the old sequence either continues unbroken or is cut over to the new start column. The full-page wrap from column 511 to column 0 is reached by starting near the top of the page and running several hundred beats before terminating.

// File: rtl/sdram_colgen_pkg.sv
// Package: shared widths and burst-length code values for the column generator.
// Assumes a 9-bit column (512-column page) and a 3-bit length code.
package sdram_colgen_pkg;
    localparam int COL_W  = 9;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_code_e;
endpackage

// File: rtl/sdram_colgen_decode.sv
// Module: translates a burst request into a wrap mask and legality.
// The mask has ones in the column bits that move during the burst.
// Assumes fixed lengths are powers of two no wider than the column.
module sdram_colgen_decode #(
    parameter int COL_W  = sdram_colgen_pkg::COL_W,
    parameter int CODE_W = sdram_colgen_pkg::CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              itl_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o,
    output logic              legal_o
);
    import sdram_colgen_pkg::*;

    // Purpose: map the length code to a mask; reject reserved settings.
    always_comb begin
        mask_o  = '0;
        page_o  = 1'b0;
        legal_o = 1'b1;
        case (code_i)
            BLEN_1:    mask_o = COL_W'(0);
            BLEN_2:    mask_o = COL_W'(1);
            BLEN_4:    mask_o = COL_W'(3);
            BLEN_8:    mask_o = COL_W'(7);
            BLEN_PAGE: begin
                mask_o  = '1;
                page_o  = 1'b1;
                legal_o = ~itl_i;
            end
            default:   legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdram_colgen_ctrl.sv
// Module: burst sequencer. Holds the captured request and the beat index.
// A legal start takes priority over terminate and over a running burst.
// Assumes the decoded mask is 2**k-1 for fixed bursts.
module sdram_colgen_ctrl #(
    parameter int COL_W = sdram_colgen_pkg::COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             itl_i,
    input  logic             page_i,
    output logic             active_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] idx_o,
    output logic             itl_o,
    output logic             page_o
);
    // Purpose: capture a request on load; hold it for the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            mask_o <= '0;
            itl_o  <= 1'b0;
            page_o <= 1'b0;
        end else if (load_i) begin
            base_o <= col_i;
            mask_o <= mask_i;
            itl_o  <= itl_i;
            page_o <= page_i;
        end
    end

    // Purpose: advance the beat index and decide when the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            idx_o    <= '0;
        end else if (load_i) begin
            active_o <= 1'b1;
            idx_o    <= '0;
        end else if (active_o) begin
            if (term_i || (!page_o && idx_o == mask_o)) begin
                active_o <= 1'b0;
            end
            idx_o <= idx_o + COL_W'(1);
        end
    end

    // The beat index never passes the last beat of a fixed burst (R2).
    assert_idx_in_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !page_o) |-> ((idx_o & ~mask_o) == '0));
endmodule

// File: rtl/sdram_colgen_addr.sv
// Module: forms the column from the captured start column and beat index.
// Bits outside the mask come from the start column. Inside the mask
// the offset is start+i (sequential) or start^i (interleaved).
// Assumes idx_i never exceeds mask_i in fixed mode.
module sdram_colgen_addr #(
    parameter int COL_W = sdram_colgen_pkg::COL_W
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic             itl_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] low_bits;

    // Purpose: pick the in-block offset by burst order, then merge.
    always_comb begin
        seq_sum  = base_i + idx_i;
        low_bits = itl_i ? (base_i ^ idx_i) : seq_sum;
        col_o    = (base_i & ~mask_i) | (low_bits & mask_i);
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Module: top of the SDRAM burst column address generator.
// One address per clock from the cycle after a legal start. Reserved
// settings are reported on cfg_err_o for one cycle and otherwise ignored.
// Assumes a synchronous active-low reset and a single clock.
module sdram_burst_colgen #(
    parameter int COL_W  = sdram_colgen_pkg::COL_W,
    parameter int CODE_W = sdram_colgen_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_code_i,
    input  logic              btype_i,
    input  logic              term_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              cfg_err_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_legal;
    logic             load;
    logic [COL_W-1:0] cur_base;
    logic [COL_W-1:0] cur_mask;
    logic [COL_W-1:0] cur_idx;
    logic             cur_itl;
    logic             cur_page;

    sdram_colgen_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) dec_i (
        .code_i  (blen_code_i),
        .itl_i   (btype_i),
        .mask_o  (dec_mask),
        .page_o  (dec_page),
        .legal_o (dec_legal)
    );

    assign load = start_i && dec_legal;

    sdram_colgen_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .term_i   (term_i),
        .col_i    (start_col_i),
        .mask_i   (dec_mask),
        .itl_i    (btype_i),
        .page_i   (dec_page),
        .active_o (valid_o),
        .base_o   (cur_base),
        .mask_o   (cur_mask),
        .idx_o    (cur_idx),
        .itl_o    (cur_itl),
        .page_o   (cur_page)
    );

    sdram_colgen_addr #(.COL_W(COL_W)) addr_i (
        .base_i (cur_base),
        .mask_i (cur_mask),
        .idx_i  (cur_idx),
        .itl_i  (cur_itl),
        .col_o  (col_o)
    );

    // Purpose: one-cycle flag for a start strobe carrying a reserved setting.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err_o <= 1'b0;
        else        cfg_err_o <= start_i && !dec_legal;
    end

    // R1: outputs idle after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !cfg_err_o));

    // R3: block bits hold for the whole of a fixed burst.
    assert_block_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(load) && !cur_page)
        |-> ((col_o & ~cur_mask) == ($past(col_o) & ~cur_mask)));

    // R6 / R10: a legal start shows its column on the next cycle.
    assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_o && col_o == $past(start_col_i)));

    // R7: full-page bursts step by one column and wrap at the page end.
    assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(load) && cur_page)
        |-> (col_o == $past(col_o) + COL_W'(1)));

    // R8: terminate ends the burst on the next cycle.
    assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !load) |=> !valid_o);

    // R9: a rejected start from idle launches nothing.
    assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec_legal && !valid_o) |=> (!valid_o && cfg_err_o));
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] blen_code_i = '0;
    logic       btype_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       cfg_err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_code_i(blen_code_i), .btype_i(btype_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .cfg_err_o(cfg_err_o)
    );

    function automatic int exp_col(int s, int code, int bt, int i);
        int m;
        int off;
        m   = (1 << code) - 1;
        off = bt ? ((s & m) ^ i) : (((s & m) + i) & m);
        return (s & ~m & 511) | off;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(int s, int code, int bt);
        start_i = 1'b1; start_col_i = 9'(s); blen_code_i = 3'(code); btype_i = bt[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", valid_o, 0);
        chk("R1 err", cfg_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: every fixed length, both orders, every start column
        for (int code = 0; code < 4; code++)
            for (int bt = 0; bt < 2; bt++)
                for (int s = 0; s < 512; s++) begin
                    launch(s, code, bt);
                    for (int i = 0; i < (1 << code); i++) begin
                        chk("R2 valid", valid_o, 1);
                        chk(bt ? "R5 col" : "R4 col", col_o, exp_col(s, code, bt, i));
                        @(negedge clk);
                    end
                    chk("R2 end", valid_o, 0);
                end

        // R7: full page wraps 511 -> 0 until terminate
        launch(300, 7, 0);
        for (int i = 0; i < 600; i++) begin
            chk("R7 valid", valid_o, 1);
            chk("R7 col", col_o, (300 + i) % 512);
            if (i == 599) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        chk("R8 page term", valid_o, 0);

        // R8: terminate in a fixed burst
        launch(16, 3, 0);
        @(negedge clk);
        term_i = 1'b1;
        chk("R8 mid col", col_o, 17);
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 fixed term", valid_o, 0);

        // R9: reserved settings from idle
        for (int code = 4; code < 8; code++) begin
            launch(5, code, 1);
            chk("R9 err", cfg_err_o, 1);
            chk("R9 no burst", valid_o, 0);
            @(negedge clk);
            chk("R9 err pulse", cfg_err_o, 0);
        end

        // R9: reserved start during a burst leaves it running
        launch(40, 3, 1);
        chk("R9 b0", col_o, exp_col(40, 3, 1, 0));
        launch(99, 5, 0);
        chk("R9 err busy", cfg_err_o, 1);
        chk("R9 b1", col_o, exp_col(40, 3, 1, 1));
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            chk("R9 run", col_o, exp_col(40, 3, 1, i));
        end
        @(negedge clk);
        chk("R9 end", valid_o, 0);

        // R10: restart partway through a burst
        launch(200, 3, 0);
        @(negedge clk);
        @(negedge clk);
        launch(77, 2, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R10 valid", valid_o, 1);
            chk("R10 col", col_o, exp_col(77, 2, 1, i));
            @(negedge clk);
        end
        chk("R10 end", valid_o, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule